// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block decides which system-management memory a host bridge exposes and to whom. It holds two 8-bit configuration registers, a control register and an extended control register. Each has a per-bit write mask. From their fields it derives enables for four windows: the legacy low window at 0xA0000–0xBFFFF (128 KiB), its high alias of the same size at 0xFEDA0000, a TSEG window just below the top of low memory, and a blackhole that hides TSEG from ordinary accesses. A sticky lock freezes the configuration until reset. A 16-bit extended-TSEG word lets firmware query the extended TSEG size that was set when the block was built.

Each cycle the block takes one address and an SMM flag, and one cycle later reports a route: RAM, PCI or blackhole. The surrounding fabric returns all ones for blackhole reads and drops blackhole writes.

A lock state machine (states CFG_OPEN and CFG_SEALED; transition SEAL, taken on a control write with the lock bit set) selects the write masks. An extended-word state machine has three states. XT_NONE is used when no extended size is configured and has no exit. XT_QUERY moves to XT_ANSWERED on the transition ANSWER, taken on a write of 0xFFFF. XT_ANSWERED has no exit. A build with an extended size above `EXT_TSEG_MAX` is rejected when it is elaborated.

Top module: `smram_tseg_ctrl`

## Requirements
- R1: After reset both control registers read 0, `locked_o` is 0, `route_o` is 0 (RAM), and `xtseg_word_o` reads 0xFFFF when `EXT_TSEG_MB` > 0 (0 otherwise).
- R2: While unlocked, control register bits [2:0] and extended register bits [3:0] take the written value. The higher bits always read 0. Control fields: bit0 open, bit1 lock, bit2 global enable. Extended fields: bit0 TSEG enable, bits[2:1] size code, bit3 high select.
- R3: A control write whose lock bit is 1 leaves the open bit 0, even if the same write sets it to 1. `locked_o` rises and stays 1 until reset.
- R4: While locked, writes to either control register leave both registers unchanged.
- R5: For a non-SMM access, the low window routes to RAM only when open=1 and high select=0, and to PCI otherwise. `nsmm_low_o` equals open AND NOT high select.
- R6: For a non-SMM access, the high alias 0xFEDA0000–0xFEDBFFFF routes to RAM only when open=1 and high select=1, and to PCI otherwise. `nsmm_high_o` equals open AND high select.
- R7: For an SMM access with global enable=1, the low window routes to RAM when high select=0 and the high alias routes to RAM when high select=1. Any other SMM case routes as a non-SMM access would. `smm_low_o` and `smm_high_o` show these two enables.
- R8: TSEG is on (`tseg_on_o`) only when TSEG enable=1, global enable=1 and the decoded size is nonzero. Size codes: 0 gives 1 MiB, 1 gives 2 MiB, 2 gives 8 MiB, 3 gives `EXT_TSEG_MB` MiB. The TSEG range is [BELOW4G − size, BELOW4G). In it, non-SMM accesses route to blackhole (code 2) and SMM accesses route to RAM.
- R9: Any other address routes to RAM (code 0) if it lies below `BELOW4G_MB` MiB, and to PCI (code 1) otherwise, whatever the SMM flag.
- R10: `route_o` shows the address and SMM flag presented one cycle earlier, decoded with the register values from before any write in that same cycle.
- R11: In the query state, writing 0xFFFF to the extended word (select 2) makes it read `EXT_TSEG_MB`. Every other write to the word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 control, 1 extended control, 2 extended-TSEG word |
| cfg_wdata | input | 16 | Write data (bytes use bits [7:0]) |
| addr_i | input | ADDR_W | Address to classify |
| smm_i | input | 1 | Access is made in SMM |
| smram_ctl_o | output | 8 | Control register value |
| ext_ctl_o | output | 8 | Extended control register value |
| xtseg_word_o | output | 16 | Extended-TSEG word value |
| locked_o | output | 1 | Configuration is sealed |
| nsmm_low_o | output | 1 | Low window visible to non-SMM accesses |
| nsmm_high_o | output | 1 | High alias visible to non-SMM accesses |
| smm_low_o | output | 1 | Low window visible to SMM accesses |
| smm_high_o | output | 1 | High alias visible to SMM accesses |
| tseg_on_o | output | 1 | TSEG window and blackhole enabled |
| route_o | output | 2 | Registered route: 0 RAM, 1 PCI, 2 blackhole |

## Verification
Two functions can fall in the same cycle: a configuration write and a lookup. The bench opens the low window and then presents a write that closes it in the same cycle as a non-SMM lookup at 0xA0000. The route for that lookup must still be RAM, and the next lookup must be PCI. The same applies to a write that sets the lock and the open bit together: the stored open bit must read 0 and later writes must be ignored. The main sweep covers every combination of open, global enable and the extended register, and probes window and TSEG edges with expected routes computed arithmetically.

// File: rtl/smram_pkg.sv
package smram_pkg;
    typedef enum logic [1:0] {
        ROUTE_RAM  = 2'd0,
        ROUTE_PCI  = 2'd1,
        ROUTE_HOLE = 2'd2
    } route_e;

    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_SEALED = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        XT_NONE     = 2'd0,
        XT_QUERY    = 2'd1,
        XT_ANSWERED = 2'd2
    } xt_state_e;

    localparam int CTL_OPEN   = 0;
    localparam int CTL_LOCK   = 1;
    localparam int CTL_GLOBAL = 2;
    localparam int EXT_TEN    = 0;
    localparam int EXT_SZ_LO  = 1;
    localparam int EXT_HSEL   = 3;

    localparam logic [7:0] CTL_MASK_OPEN   = 8'h07;
    localparam logic [7:0] CTL_MASK_SEALED = 8'h00;
    localparam logic [7:0] EXT_MASK_OPEN   = 8'h0F;
    localparam logic [7:0] EXT_MASK_SEALED = 8'h00;

    localparam logic [1:0] SEL_CTL = 2'd0;
    localparam logic [1:0] SEL_EXT = 2'd1;
    localparam logic [1:0] SEL_XT  = 2'd2;

    localparam logic [15:0] XT_QUERY_VAL = 16'hFFFF;

    typedef struct packed {
        logic nsmm_low;
        logic nsmm_high;
        logic smm_low;
        logic smm_high;
        logic tseg_on;
    } win_t;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] sel,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_o,
    output logic [7:0] ext_o,
    output logic       locked_o
);
    lock_state_e st_q, st_d;
    logic [7:0]  ctl_q, ext_q, ctl_d, ext_d;
    logic [7:0]  ctl_mask, ext_mask;
    logic        ctl_hit, ext_hit;

    assign ctl_hit = we && (sel == SEL_CTL);
    assign ext_hit = we && (sel == SEL_EXT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CFG_OPEN;
        else        st_q <= st_d;
    end

    // transitions: SEAL is the only one
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CFG_OPEN:   if (ctl_hit && wdata[CTL_LOCK]) st_d = CFG_SEALED;
            CFG_SEALED: st_d = CFG_SEALED;
        endcase
    end

    // per-state outputs: write masks
    always_comb begin
        unique case (st_q)
            CFG_OPEN: begin
                ctl_mask = CTL_MASK_OPEN;
                ext_mask = EXT_MASK_OPEN;
            end
            CFG_SEALED: begin
                ctl_mask = CTL_MASK_SEALED;
                ext_mask = EXT_MASK_SEALED;
            end
        endcase
    end

    always_comb begin
        ctl_d = ctl_q;
        ext_d = ext_q;
        if (ctl_hit) begin
            ctl_d = (ctl_q & ~ctl_mask) | (wdata & ctl_mask);
            if (ctl_d[CTL_LOCK]) ctl_d[CTL_OPEN] = 1'b0;
        end
        if (ext_hit) begin
            ext_d = (ext_q & ~ext_mask) | (wdata & ext_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ext_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            ext_q <= ext_d;
        end
    end

    assign ctl_o    = ctl_q;
    assign ext_o    = ext_q;
    assign locked_o = (st_q == CFG_SEALED);
endmodule

// File: rtl/smram_xtseg.sv
module smram_xtseg
    import smram_pkg::*;
#(
    parameter int EXT_MB = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] word_o
);
    localparam xt_state_e RST_ST = (EXT_MB > 0) ? XT_QUERY : XT_NONE;
    localparam logic [15:0] EXT_WORD = 16'(EXT_MB);

    xt_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    // transitions: ANSWER from query on a write of the query value
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XT_NONE:     st_d = XT_NONE;
            XT_QUERY:    if (we && wdata == XT_QUERY_VAL) st_d = XT_ANSWERED;
            XT_ANSWERED: st_d = XT_ANSWERED;
            default:     st_d = RST_ST;
        endcase
    end

    always_comb begin
        unique case (st_q)
            XT_NONE:     word_o = '0;
            XT_QUERY:    word_o = XT_QUERY_VAL;
            XT_ANSWERED: word_o = EXT_WORD;
            default:     word_o = '0;
        endcase
    end
endmodule

// File: rtl/smram_decode.sv
module smram_decode
    import smram_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                BELOW4G_MB  = 2048,
    parameter int                EXT_TSEG_MB = 16,
    parameter logic [ADDR_W-1:0] LOW_BASE    = 'h000A0000,
    parameter logic [ADDR_W-1:0] HIGH_BASE   = 'hFEDA0000,
    parameter logic [ADDR_W-1:0] WIN_BYTES   = 'h00020000
) (
    input  logic              open_i,
    input  logic              global_i,
    input  logic              hsel_i,
    input  logic              tseg_en_i,
    input  logic [1:0]        tsize_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              smm_i,
    output win_t              win_o,
    output route_e            route_o
);
    localparam int                MB_W     = ADDR_W - 19;
    localparam logic [MB_W-1:0]   BELOW_MB = MB_W'(BELOW4G_MB);
    localparam logic [MB_W-1:0]   EXT_MB   = MB_W'(EXT_TSEG_MB);
    localparam logic [ADDR_W-1:0] LOW_END  = LOW_BASE + WIN_BYTES;
    localparam logic [ADDR_W-1:0] HIGH_END = HIGH_BASE + WIN_BYTES;

    logic [MB_W-1:0] tseg_mb, tseg_lo, addr_mb;
    logic            in_low, in_high, in_tseg, below;

    always_comb begin
        unique case (tsize_i)
            2'd0: tseg_mb = MB_W'(1);
            2'd1: tseg_mb = MB_W'(2);
            2'd2: tseg_mb = MB_W'(8);
            2'd3: tseg_mb = EXT_MB;
        endcase
    end

    assign win_o.nsmm_low  = open_i && !hsel_i;
    assign win_o.nsmm_high = open_i &&  hsel_i;
    assign win_o.smm_low   = global_i && !hsel_i;
    assign win_o.smm_high  = global_i &&  hsel_i;
    assign win_o.tseg_on   = tseg_en_i && global_i && (tseg_mb != '0);

    assign addr_mb = {1'b0, addr_i[ADDR_W-1:20]};
    assign tseg_lo = BELOW_MB - tseg_mb;
    assign below   = addr_mb < BELOW_MB;
    assign in_low  = (addr_i >= LOW_BASE)  && (addr_i < LOW_END);
    assign in_high = (addr_i >= HIGH_BASE) && (addr_i < HIGH_END);
    assign in_tseg = win_o.tseg_on && below && (addr_mb >= tseg_lo);

    always_comb begin
        if (in_high) begin
            route_o = ((smm_i && win_o.smm_high) || win_o.nsmm_high) ? ROUTE_RAM : ROUTE_PCI;
        end else if (in_low) begin
            route_o = ((smm_i && win_o.smm_low) || win_o.nsmm_low) ? ROUTE_RAM : ROUTE_PCI;
        end else if (in_tseg) begin
            route_o = smm_i ? ROUTE_RAM : ROUTE_HOLE;
        end else begin
            route_o = below ? ROUTE_RAM : ROUTE_PCI;
        end
    end
endmodule

// File: rtl/smram_tseg_ctrl.sv
module smram_tseg_ctrl
    import smram_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                BELOW4G_MB   = 2048,
    parameter int                EXT_TSEG_MB  = 16,
    parameter int                EXT_TSEG_MAX = 4095,
    parameter logic [ADDR_W-1:0] LOW_BASE     = 'h000A0000,
    parameter logic [ADDR_W-1:0] HIGH_BASE    = 'hFEDA0000,
    parameter logic [ADDR_W-1:0] WIN_BYTES    = 'h00020000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              smm_i,
    output logic [7:0]        smram_ctl_o,
    output logic [7:0]        ext_ctl_o,
    output logic [15:0]       xtseg_word_o,
    output logic              locked_o,
    output logic              nsmm_low_o,
    output logic              nsmm_high_o,
    output logic              smm_low_o,
    output logic              smm_high_o,
    output logic              tseg_on_o,
    output logic [1:0]        route_o
);
    generate
        if (EXT_TSEG_MB > EXT_TSEG_MAX) begin : g_bad_ext
            $error("extended TSEG size exceeds the allowed maximum");
        end
    endgenerate

    logic [7:0] ctl, ext;
    win_t       win;
    route_e     route_d, route_q;

    smram_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata[7:0]),
        .ctl_o    (ctl),
        .ext_o    (ext),
        .locked_o (locked_o)
    );

    smram_xtseg #(.EXT_MB(EXT_TSEG_MB)) u_xt (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we && cfg_sel == SEL_XT),
        .wdata  (cfg_wdata),
        .word_o (xtseg_word_o)
    );

    smram_decode #(
        .ADDR_W      (ADDR_W),
        .BELOW4G_MB  (BELOW4G_MB),
        .EXT_TSEG_MB (EXT_TSEG_MB),
        .LOW_BASE    (LOW_BASE),
        .HIGH_BASE   (HIGH_BASE),
        .WIN_BYTES   (WIN_BYTES)
    ) u_dec (
        .open_i    (ctl[CTL_OPEN]),
        .global_i  (ctl[CTL_GLOBAL]),
        .hsel_i    (ext[EXT_HSEL]),
        .tseg_en_i (ext[EXT_TEN]),
        .tsize_i   (ext[EXT_SZ_LO +: 2]),
        .addr_i    (addr_i),
        .smm_i     (smm_i),
        .win_o     (win),
        .route_o   (route_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= ROUTE_RAM;
        else        route_q <= route_d;
    end

    assign smram_ctl_o = ctl;
    assign ext_ctl_o   = ext;
    assign nsmm_low_o  = win.nsmm_low;
    assign nsmm_high_o = win.nsmm_high;
    assign smm_low_o   = win.smm_low;
    assign smm_high_o  = win.smm_high;
    assign tseg_on_o   = win.tseg_on;
    assign route_o     = route_q;
endmodule

// File: rtl/smram_tseg_chk.sv
module smram_tseg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        smm_i,
    input logic [7:0]  smram_ctl_o,
    input logic [7:0]  ext_ctl_o,
    input logic [15:0] xtseg_word_o,
    input logic        locked_o,
    input logic        nsmm_low_o,
    input logic        nsmm_high_o,
    input logic        smm_low_o,
    input logic        smm_high_o,
    input logic        tseg_on_o,
    input logic [1:0]  route_o
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smram_ctl_o[7:3] == 5'd0 && ext_ctl_o[7:4] == 4'd0);

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    p_lock_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (smram_ctl_o[1] && !smram_ctl_o[0]));

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked_o) |-> ($stable(smram_ctl_o) && $stable(ext_ctl_o)));

    p_nsmm_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(nsmm_low_o && nsmm_high_o));

    p_smm_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(smm_low_o && smm_high_o) && ((smm_low_o || smm_high_o) -> smram_ctl_o[2]));

    p_tseg_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tseg_on_o |-> (ext_ctl_o[0] && smram_ctl_o[2]));

    p_hole_nsmm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (route_o == 2'd2) |-> !$past(smm_i));

    p_xt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xtseg_word_o != 16'hFFFF) |=> $stable(xtseg_word_o));
endmodule

bind smram_tseg_ctrl smram_tseg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smm_i        (smm_i),
    .smram_ctl_o  (smram_ctl_o),
    .ext_ctl_o    (ext_ctl_o),
    .xtseg_word_o (xtseg_word_o),
    .locked_o     (locked_o),
    .nsmm_low_o   (nsmm_low_o),
    .nsmm_high_o  (nsmm_high_o),
    .smm_low_o    (smm_low_o),
    .smm_high_o   (smm_high_o),
    .tseg_on_o    (tseg_on_o),
    .route_o      (route_o)
);

// File: tb/tb_smram_tseg_ctrl.sv
`timescale 1ns/1ps
module tb_smram_tseg_ctrl;
    localparam int EXT_MB = 16;
    localparam logic [31:0] BELOW = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [31:0] addr_i = 32'h0;
    logic        smm_i = 1'b0;
    logic [7:0]  smram_ctl_o, ext_ctl_o;
    logic [15:0] xtseg_word_o;
    logic        locked_o, nsmm_low_o, nsmm_high_o, smm_low_o, smm_high_o, tseg_on_o;
    logic [1:0]  route_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  m_ctl = 8'h0;
    logic [7:0]  m_ext = 8'h0;
    bit          m_lock = 1'b0;
    logic [15:0] m_xt = 16'hFFFF;

    always #4 clk = ~clk;

    smram_tseg_ctrl #(.EXT_TSEG_MB(EXT_MB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .addr_i(addr_i), .smm_i(smm_i),
        .smram_ctl_o(smram_ctl_o), .ext_ctl_o(ext_ctl_o),
        .xtseg_word_o(xtseg_word_o), .locked_o(locked_o),
        .nsmm_low_o(nsmm_low_o), .nsmm_high_o(nsmm_high_o),
        .smm_low_o(smm_low_o), .smm_high_o(smm_high_o),
        .tseg_on_o(tseg_on_o), .route_o(route_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int tsize_mb();
        case (m_ext[2:1])
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 8;
            default: return EXT_MB;
        endcase
    endfunction

    function automatic logic [1:0] exp_route(input logic [31:0] a, input bit s);
        bit o = m_ctl[0];
        bit g = m_ctl[2];
        bit h = m_ext[3];
        bit t = m_ext[0] && g && (tsize_mb() != 0);
        logic [31:0] base = BELOW - (32'(tsize_mb()) << 20);
        if (a >= 32'hFEDA0000 && a < 32'hFEDC0000)
            return ((s && g && h) || (o && h)) ? 2'd0 : 2'd1;
        else if (a >= 32'h000A0000 && a < 32'h000C0000)
            return ((s && g && !h) || (o && !h)) ? 2'd0 : 2'd1;
        else if (t && a >= base && a < BELOW)
            return s ? 2'd0 : 2'd2;
        else
            return (a < BELOW) ? 2'd0 : 2'd1;
    endfunction

    task automatic model_write(input logic [1:0] s, input logic [15:0] d);
        logic [7:0] nc;
        if (s == 2'd0 && !m_lock) begin
            nc = {5'b0, d[2:0]};
            if (nc[1]) begin
                nc[0] = 1'b0;
                m_lock = 1'b1;
            end
            m_ctl = nc;
        end else if (s == 2'd1 && !m_lock) begin
            m_ext = {4'b0, d[3:0]};
        end else if (s == 2'd2) begin
            if (m_xt == 16'hFFFF && d == 16'hFFFF) m_xt = 16'(EXT_MB);
        end
    endtask

    // called just after a falling edge
    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(s, d);
    endtask

    task automatic probe(input string tag, input logic [31:0] a, input bit s);
        addr_i = a; smm_i = s;
        @(negedge clk);
        chk(tag, {30'b0, route_o}, {30'b0, exp_route(a, s)});
    endtask

    task automatic check_windows();
        chk("R5 nsmm_low",  {31'b0, nsmm_low_o},  {31'b0, m_ctl[0] && !m_ext[3]});
        chk("R6 nsmm_high", {31'b0, nsmm_high_o}, {31'b0, m_ctl[0] &&  m_ext[3]});
        chk("R7 smm_low",   {31'b0, smm_low_o},   {31'b0, m_ctl[2] && !m_ext[3]});
        chk("R7 smm_high",  {31'b0, smm_high_o},  {31'b0, m_ctl[2] &&  m_ext[3]});
        chk("R8 tseg_on",   {31'b0, tseg_on_o},   {31'b0, m_ext[0] && m_ctl[2]});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ctl = 8'h0; m_ext = 8'h0; m_lock = 1'b0; m_xt = 16'hFFFF;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] tbase;
        do_reset();
        // R1 reset state
        chk("R1 ctl", {24'b0, smram_ctl_o}, 32'h0);
        chk("R1 ext", {24'b0, ext_ctl_o}, 32'h0);
        chk("R1 locked", {31'b0, locked_o}, 32'h0);
        chk("R1 route", {30'b0, route_o}, 32'h0);
        chk("R1 xtseg", {16'b0, xtseg_word_o}, 32'hFFFF);

        // sweep open/global x every extended setting
        for (int c = 0; c < 8; c++) begin
            if (c[1]) continue;
            for (int e = 0; e < 16; e++) begin
                wr(2'd0, 16'h00F8 | 16'(c));
                wr(2'd1, 16'h00F0 | 16'(e));
                chk("R2 ctl", {24'b0, smram_ctl_o}, {24'b0, m_ctl});
                chk("R2 ext", {24'b0, ext_ctl_o}, {24'b0, m_ext});
                check_windows();
                tbase = BELOW - (32'(tsize_mb()) << 20);
                for (int s = 0; s < 2; s++) begin
                    probe("R5 low-1",   32'h0009FFFF, s[0]);
                    probe("R5 low lo",  32'h000A0000, s[0]);
                    probe("R7 low hi",  32'h000BFFFF, s[0]);
                    probe("R9 low end", 32'h000C0000, s[0]);
                    probe("R9 hi-1",    32'hFED9FFFF, s[0]);
                    probe("R6 hi lo",   32'hFEDA0000, s[0]);
                    probe("R7 hi hi",   32'hFEDBFFFF, s[0]);
                    probe("R9 hi end",  32'hFEDC0000, s[0]);
                    probe("R8 tseg-1",  tbase - 32'd1, s[0]);
                    probe("R8 tseg lo", tbase, s[0]);
                    probe("R8 tseg hi", BELOW - 32'd1, s[0]);
                    probe("R9 below",   BELOW, s[0]);
                    probe("R9 zero",    32'h0, s[0]);
                end
            end
        end

        // R10: write and lookup in the same cycle
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0001);
        addr_i = 32'h000A0000; smm_i = 1'b0;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h0000;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R10 old config used", {30'b0, route_o}, 32'd0);
        model_write(2'd0, 16'h0000);
        probe("R10 new config", 32'h000A0000, 1'b0);
        chk("R10 new route pci", {30'b0, route_o}, 32'd1);

        // R11 extended word
        wr(2'd2, 16'h1234);
        chk("R11 ignored write", {16'b0, xtseg_word_o}, 32'hFFFF);
        wr(2'd2, 16'hFFFF);
        chk("R11 answer", {16'b0, xtseg_word_o}, 32'(EXT_MB));
        wr(2'd2, 16'hFFFF);
        chk("R11 stays", {16'b0, xtseg_word_o}, 32'(EXT_MB));

        // R3 lock with open in the same write
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'h0007);
        chk("R3 open cleared", {24'b0, smram_ctl_o}, 32'h06);
        chk("R3 locked", {31'b0, locked_o}, 32'h1);
        // R4 writes ignored while locked
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h000E);
        chk("R4 ctl frozen", {24'b0, smram_ctl_o}, 32'h06);
        chk("R4 ext frozen", {24'b0, ext_ctl_o}, 32'h01);
        chk("R3 still locked", {31'b0, locked_o}, 32'h1);
        probe("R4 low closed", 32'h000A0000, 1'b0);
        probe("R8 hole locked", BELOW - 32'd1, 1'b0);

        // reset releases the lock
        do_reset();
        chk("R3 unlocked by reset", {31'b0, locked_o}, 32'h0);
        chk("R1 xtseg again", {16'b0, xtseg_word_o}, 32'hFFFF);
        wr(2'd0, 16'h0001);
        chk("R2 writable again", {24'b0, smram_ctl_o}, 32'h01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule